// File: doc/BRIEF.md
# I2C Host Bus Timing Engine

This block is the bit-level line driver of an I2C host. A caller hands it one primitive bus operation at a time: START, transmit one bit, receive one bit, or STOP. A START issued while a transaction is already open becomes a repeated START. The engine splits each primitive into a short series of phases. Every phase holds SCL and SDA at fixed levels for a number of input clock cycles taken from ten programmable 16-bit counts: SCL high, SCL low, rise, fall, START setup, START hold, data setup, data hold, STOP setup and bus free.

The lines are driven open-drain. An output enable of 1 pulls its line low, and an enable of 0 releases it so the line floats high. A software override can take both lines away from the state machine. Each line also has a sample history shift register. Byte framing, command queues, clock stretching and arbitration belong to the blocks around this one.

Top module: `i2c_bus_engine`

## Requirements
- R1: While reset is asserted, `scl_oe` and `sda_oe` are 0, `busy` and `done` are 0, and both history registers read zero.
- R2: While `host_en` is 0, commands are ignored, `busy` stays 0, and the state machine releases both lines. Clearing `host_en` during a primitive abandons it: in the following cycle `busy` is 0, the lines are released, and the transaction is no longer open.
- R3: Command code 2'b00 with no open transaction is a fresh START. The engine holds SCL and SDA released for tSTA_SU+1 cycles, then SDA low with SCL released for tSTA_HD+1 cycles, then both low for tFALL+1 cycles. The transaction is then open.
- R4: Command code 2'b00 with a transaction open is a repeated START. The engine holds SCL low with SDA unchanged for tDAT_HD+1 cycles, then SDA released for tLOW+1 cycles, then SCL released for tRISE+tSTA_SU+1 cycles, then SDA low for tSTA_HD+1 cycles, then both low for tFALL+1 cycles.
- R5: Command code 2'b01 transmits `cmd_bit`. The engine holds SCL low with SDA unchanged for tDAT_HD+1 cycles, then SDA at the bit for tLOW+tDAT_SU+1 cycles, then SCL released for tRISE+tHIGH+1 cycles, then SCL low for tFALL+1 cycles. During data bits SDA changes only while SCL is held low.
- R6: Command code 2'b10 receives a bit. It uses the same phases as R5 with SDA released. `sda_i` is sampled on the last cycle of the SCL-high phase, and the sample appears on `rx_bit` when `done` rises.
- R7: Command code 2'b11 is a STOP. The engine holds SCL low with SDA unchanged for tDAT_HD+1 cycles, then SDA low for tLOW+1 cycles, then SCL released for tRISE+tSTO_SU+1 cycles, then both released for tBUF+1 cycles. The transaction is then closed. The bus-free time is part of the STOP, so no START can follow before it has elapsed.
- R8: A command is taken when `cmd_valid`, `host_en` and not `busy` hold at a clock edge. `busy` is 1 from the next cycle through the last phase. `done` is a one-cycle pulse with `busy` low. A command may be taken in the `done` cycle.
- R9: While `ovr_en` is 1, `scl_oe` equals the inverse of `ovr_scl` and `sda_oe` equals the inverse of `ovr_sda`. The state machine keeps its own timing underneath.
- R10: On every clock edge out of reset, each history register shifts left and takes the current line input into bit 0, so bit 0 is the newest sample and bit 15 the oldest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_en | input | 1 | Enables the engine |
| ovr_en | input | 1 | Override mode select |
| ovr_scl | input | 1 | Override SCL level |
| ovr_sda | input | 1 | Override SDA level |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 00 START, 01 transmit, 10 receive, 11 STOP |
| cmd_bit | input | 1 | Bit to transmit |
| tm_hi | input | TW | SCL high count |
| tm_lo | input | TW | SCL low count |
| tm_rise | input | TW | Rise count |
| tm_fall | input | TW | Fall count |
| tm_sta_su | input | TW | START setup count |
| tm_sta_hd | input | TW | START hold count |
| tm_dat_su | input | TW | Data setup count |
| tm_dat_hd | input | TW | Data hold count |
| tm_sto_su | input | TW | STOP setup count |
| tm_idle | input | TW | Bus free count |
| scl_i | input | 1 | SCL line input |
| sda_i | input | 1 | SDA line input |
| scl_oe | output | 1 | SCL pull-low enable |
| sda_oe | output | 1 | SDA pull-low enable |
| busy | output | 1 | Primitive in progress |
| done | output | 1 | Primitive completion pulse |
| rx_bit | output | 1 | Last received bit |
| scl_hist | output | HD | SCL sample history |
| sda_hist | output | HD | SDA sample history |

## Verification
The bench checks two pairs of functions that can fall in the same cycle. The first pair is the completion pulse and the next command. The bench issues commands back to back, so each new one is taken in the cycle `done` is high. The second pair is the override and a running primitive. The bench switches `ovr_en` on and off in the middle of a transmit. The lines must follow the override bits, and after the override is released the phase timing must continue where the reference model says. A reference model that works from phase lists is compared with the design on every cycle. It also checks a clear of `host_en` that lands in the middle of a START.

// File: rtl/i2c_bus_pkg.sv
package i2c_bus_pkg;

  typedef enum logic [2:0] {
    K_START  = 3'd0,
    K_RSTART = 3'd1,
    K_TX     = 3'd2,
    K_RX     = 3'd3,
    K_STOP   = 3'd4
  } kind_e;

  localparam logic [1:0] OP_START = 2'b00;
  localparam logic [1:0] OP_TX    = 2'b01;
  localparam logic [1:0] OP_RX    = 2'b10;
  localparam logic [1:0] OP_STOP  = 2'b11;

  localparam int NUM_T     = 10;
  localparam int IX_HI     = 0;
  localparam int IX_LO     = 1;
  localparam int IX_RISE   = 2;
  localparam int IX_FALL   = 3;
  localparam int IX_STA_SU = 4;
  localparam int IX_STA_HD = 5;
  localparam int IX_DAT_SU = 6;
  localparam int IX_DAT_HD = 7;
  localparam int IX_STO_SU = 8;
  localparam int IX_IDLE   = 9;

endpackage

// File: rtl/i2c_bus_phase.sv
module i2c_bus_phase
  import i2c_bus_pkg::*;
#(
  parameter int TW = 16
) (
  input  kind_e                 kind,
  input  logic [2:0]            step,
  input  logic                  bit_i,
  input  logic                  prev_sda,
  input  logic [NUM_T*TW-1:0]   tim,
  output logic                  scl,
  output logic                  sda,
  output logic                  last,
  output logic [TW+1:0]         len
);
  localparam int CW = TW + 2;

  logic [CW-1:0] hi, lo, rise, fall, sta_su, sta_hd, dat_su, dat_hd, sto_su, idle;

  assign hi     = CW'(tim[IX_HI*TW     +: TW]);
  assign lo     = CW'(tim[IX_LO*TW     +: TW]);
  assign rise   = CW'(tim[IX_RISE*TW   +: TW]);
  assign fall   = CW'(tim[IX_FALL*TW   +: TW]);
  assign sta_su = CW'(tim[IX_STA_SU*TW +: TW]);
  assign sta_hd = CW'(tim[IX_STA_HD*TW +: TW]);
  assign dat_su = CW'(tim[IX_DAT_SU*TW +: TW]);
  assign dat_hd = CW'(tim[IX_DAT_HD*TW +: TW]);
  assign sto_su = CW'(tim[IX_STO_SU*TW +: TW]);
  assign idle   = CW'(tim[IX_IDLE*TW   +: TW]);

  // Phase table: levels (1 = released) and count load (phase lasts len+1 cycles)
  always_comb begin
    scl  = 1'b1;
    sda  = 1'b1;
    last = 1'b0;
    len  = '0;
    case (kind)
      K_START: begin
        case (step)
          3'd0:    begin scl = 1'b1; sda = 1'b1; len = sta_su; end
          3'd1:    begin scl = 1'b1; sda = 1'b0; len = sta_hd; end
          default: begin scl = 1'b0; sda = 1'b0; len = fall; last = 1'b1; end
        endcase
      end
      K_RSTART: begin
        case (step)
          3'd0:    begin scl = 1'b0; sda = prev_sda; len = dat_hd; end
          3'd1:    begin scl = 1'b0; sda = 1'b1; len = lo; end
          3'd2:    begin scl = 1'b1; sda = 1'b1; len = rise + sta_su; end
          3'd3:    begin scl = 1'b1; sda = 1'b0; len = sta_hd; end
          default: begin scl = 1'b0; sda = 1'b0; len = fall; last = 1'b1; end
        endcase
      end
      K_TX, K_RX: begin
        case (step)
          3'd0:    begin scl = 1'b0; sda = prev_sda; len = dat_hd; end
          3'd1:    begin scl = 1'b0; sda = (kind == K_RX) | bit_i; len = lo + dat_su; end
          3'd2:    begin scl = 1'b1; sda = (kind == K_RX) | bit_i; len = rise + hi; end
          default: begin scl = 1'b0; sda = (kind == K_RX) | bit_i; len = fall; last = 1'b1; end
        endcase
      end
      default: begin
        case (step)
          3'd0:    begin scl = 1'b0; sda = prev_sda; len = dat_hd; end
          3'd1:    begin scl = 1'b0; sda = 1'b0; len = lo; end
          3'd2:    begin scl = 1'b1; sda = 1'b0; len = rise + sto_su; end
          default: begin scl = 1'b1; sda = 1'b1; len = idle; last = 1'b1; end
        endcase
      end
    endcase
  end

endmodule

// File: rtl/i2c_bus_seq.sv
module i2c_bus_seq
  import i2c_bus_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_en,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_op,
  input  logic                cmd_bit,
  input  logic [NUM_T*TW-1:0] tim,
  input  logic                sda_in,
  output logic                busy,
  output logic                done,
  output logic                rx_bit,
  output logic                scl_lvl,
  output logic                sda_lvl,
  output kind_e               kind_o
);
  localparam int CW = TW + 2;

  kind_e         kind_q, kind_n, acc_kind;
  logic [2:0]    step_q, step_n, step_nx;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          busy_q, busy_n, done_q, done_n, open_q, open_n;
  logic          bit_q, bit_n, prev_q, prev_n, last_q, last_n;
  logic          scl_q, scl_n, sda_q, sda_n, rx_q, rx_n;
  logic          accept;

  logic          a_scl, a_sda, a_last;
  logic [CW-1:0] a_len;
  logic          b_scl, b_sda, b_last;
  logic [CW-1:0] b_len;

  assign accept  = host_en & cmd_valid & ~busy_q;
  assign step_nx = 3'(step_q + 3'd1);

  always_comb begin
    case (cmd_op)
      OP_START: acc_kind = open_q ? K_RSTART : K_START;
      OP_TX:    acc_kind = K_TX;
      OP_RX:    acc_kind = K_RX;
      default:  acc_kind = K_STOP;
    endcase
  end

  // Entry phase of a newly accepted command
  i2c_bus_phase #(.TW(TW)) u_entry (
    .kind(acc_kind), .step(3'd0), .bit_i(cmd_bit), .prev_sda(sda_q), .tim(tim),
    .scl(a_scl), .sda(a_sda), .last(a_last), .len(a_len)
  );

  // Following phase of the running command
  i2c_bus_phase #(.TW(TW)) u_next (
    .kind(kind_q), .step(step_nx), .bit_i(bit_q), .prev_sda(prev_q), .tim(tim),
    .scl(b_scl), .sda(b_sda), .last(b_last), .len(b_len)
  );

  always_comb begin
    kind_n = kind_q;
    step_n = step_q;
    cnt_n  = cnt_q;
    busy_n = busy_q;
    done_n = 1'b0;
    open_n = open_q;
    bit_n  = bit_q;
    prev_n = prev_q;
    last_n = last_q;
    scl_n  = scl_q;
    sda_n  = sda_q;
    rx_n   = rx_q;
    if (!host_en) begin
      busy_n = 1'b0;
      open_n = 1'b0;
      scl_n  = 1'b1;
      sda_n  = 1'b1;
      cnt_n  = '0;
      step_n = '0;
    end else if (busy_q) begin
      if (cnt_q != '0) begin
        cnt_n = cnt_q - 1'b1;
      end else begin
        if (kind_q == K_RX && step_q == 3'd2) rx_n = sda_in;
        if (last_q) begin
          busy_n = 1'b0;
          done_n = 1'b1;
          if (kind_q == K_START || kind_q == K_RSTART) open_n = 1'b1;
          else if (kind_q == K_STOP) open_n = 1'b0;
        end else begin
          step_n = step_nx;
          scl_n  = b_scl;
          sda_n  = b_sda;
          cnt_n  = b_len;
          last_n = b_last;
        end
      end
    end else if (accept) begin
      kind_n = acc_kind;
      step_n = '0;
      bit_n  = cmd_bit;
      prev_n = sda_q;
      busy_n = 1'b1;
      scl_n  = a_scl;
      sda_n  = a_sda;
      cnt_n  = a_len;
      last_n = a_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= K_START;
      step_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      open_q <= 1'b0;
      bit_q  <= 1'b0;
      prev_q <= 1'b1;
      last_q <= 1'b0;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      rx_q   <= 1'b0;
    end else begin
      kind_q <= kind_n;
      step_q <= step_n;
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
      done_q <= done_n;
      open_q <= open_n;
      bit_q  <= bit_n;
      prev_q <= prev_n;
      last_q <= last_n;
      scl_q  <= scl_n;
      sda_q  <= sda_n;
      rx_q   <= rx_n;
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_bit  = rx_q;
  assign scl_lvl = scl_q;
  assign sda_lvl = sda_q;
  assign kind_o  = kind_q;

endmodule

// File: rtl/i2c_bus_hist.sv
module i2c_bus_hist #(
  parameter int LINES = 2,
  parameter int DEPTH = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LINES-1:0]       line_i,
  output logic [LINES*DEPTH-1:0] hist
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [DEPTH-1:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[DEPTH-2:0], line_i[g]};
    end
    assign hist[g*DEPTH +: DEPTH] = sh_q;
  end
endmodule

// File: rtl/i2c_bus_pinmux.sv
module i2c_bus_pinmux (
  input  logic ovr_en,
  input  logic ovr_scl,
  input  logic ovr_sda,
  input  logic scl_lvl,
  input  logic sda_lvl,
  output logic scl_oe,
  output logic sda_oe
);
  // Open-drain: enable pulls low, so enable is the inverse of the wanted level
  always_comb begin
    if (ovr_en) begin
      scl_oe = ~ovr_scl;
      sda_oe = ~ovr_sda;
    end else begin
      scl_oe = ~scl_lvl;
      sda_oe = ~sda_lvl;
    end
  end
endmodule

// File: rtl/i2c_bus_engine.sv
module i2c_bus_engine
  import i2c_bus_pkg::*;
#(
  parameter int TW = 16,
  parameter int HD = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_en,
  input  logic          ovr_en,
  input  logic          ovr_scl,
  input  logic          ovr_sda,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic          cmd_bit,
  input  logic [TW-1:0] tm_hi,
  input  logic [TW-1:0] tm_lo,
  input  logic [TW-1:0] tm_rise,
  input  logic [TW-1:0] tm_fall,
  input  logic [TW-1:0] tm_sta_su,
  input  logic [TW-1:0] tm_sta_hd,
  input  logic [TW-1:0] tm_dat_su,
  input  logic [TW-1:0] tm_dat_hd,
  input  logic [TW-1:0] tm_sto_su,
  input  logic [TW-1:0] tm_idle,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          busy,
  output logic          done,
  output logic          rx_bit,
  output logic [HD-1:0] scl_hist,
  output logic [HD-1:0] sda_hist
);
  logic [NUM_T*TW-1:0] tim;
  logic                scl_lvl, sda_lvl;
  kind_e               seq_kind;
  logic [2*HD-1:0]     hist_all;

  assign tim = {tm_idle, tm_sto_su, tm_dat_hd, tm_dat_su, tm_sta_hd,
                tm_sta_su, tm_fall, tm_rise, tm_lo, tm_hi};

  i2c_bus_seq #(.TW(TW)) u_seq (
    .clk(clk), .rst_n(rst_n), .host_en(host_en), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_bit(cmd_bit), .tim(tim), .sda_in(sda_i),
    .busy(busy), .done(done), .rx_bit(rx_bit),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .kind_o(seq_kind)
  );

  i2c_bus_pinmux u_mux (
    .ovr_en(ovr_en), .ovr_scl(ovr_scl), .ovr_sda(ovr_sda),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  i2c_bus_hist #(.LINES(2), .DEPTH(HD)) u_hist (
    .clk(clk), .rst_n(rst_n), .line_i({sda_i, scl_i}), .hist(hist_all)
  );

  assign scl_hist = hist_all[HD-1:0];
  assign sda_hist = hist_all[2*HD-1:HD];

endmodule

// File: rtl/i2c_bus_engine_chk.sv
module i2c_bus_engine_chk #(
  parameter int HD = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_en,
  input logic          busy,
  input logic          done,
  input logic [2:0]    kind,
  input logic          scl_lvl,
  input logic          sda_lvl,
  input logic          scl_i,
  input logic          sda_i,
  input logic [HD-1:0] scl_hist,
  input logic [HD-1:0] sda_hist
);
  logic data_kind;
  assign data_kind = (kind == 3'd2) || (kind == 3'd3);

  assert_idle_when_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !host_en |=> (!busy && !done));

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_end_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(host_en) && $fell(busy)) |-> done);

  assert_sda_moves_scl_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && data_kind && (sda_lvl != $past(sda_lvl)))
      |-> (!scl_lvl && !$past(scl_lvl)));

  assert_hist_newest_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (scl_hist[0] == $past(scl_i) && sda_hist[0] == $past(sda_i)));

  assert_hist_shift_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (scl_hist[HD-1:1] == $past(scl_hist[HD-2:0])
                      && sda_hist[HD-1:1] == $past(sda_hist[HD-2:0])));
endmodule

bind i2c_bus_engine i2c_bus_engine_chk #(.HD(HD)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_en(host_en), .busy(busy), .done(done),
  .kind(seq_kind), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
  .scl_i(scl_i), .sda_i(sda_i), .scl_hist(scl_hist), .sda_hist(sda_hist)
);

// File: tb/sim_i2c_bus_engine.sv
module sim_i2c_bus_engine;
  localparam int TW = 16;
  localparam int HD = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, host_en, ovr_en, ovr_scl, ovr_sda, cmd_valid, cmd_bit, tgt_sda;
  logic [1:0] cmd_op;
  logic [TW-1:0] t_hi, t_lo, t_ri, t_fa, t_ss, t_sh, t_ds, t_dh, t_ps, t_id;
  logic scl_i, sda_i, scl_oe, sda_oe, busy, done, rx_bit;
  logic [HD-1:0] scl_hist, sda_hist;

  assign scl_i = ~scl_oe;
  assign sda_i = sda_oe ? 1'b0 : tgt_sda;

  i2c_bus_engine #(.TW(TW), .HD(HD)) u0 (
    .clk(clk), .rst_n(rst_n), .host_en(host_en), .ovr_en(ovr_en),
    .ovr_scl(ovr_scl), .ovr_sda(ovr_sda), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bit(cmd_bit), .tm_hi(t_hi), .tm_lo(t_lo), .tm_rise(t_ri), .tm_fall(t_fa),
    .tm_sta_su(t_ss), .tm_sta_hd(t_sh), .tm_dat_su(t_ds), .tm_dat_hd(t_dh),
    .tm_sto_su(t_ps), .tm_idle(t_id), .scl_i(scl_i), .sda_i(sda_i),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done), .rx_bit(rx_bit),
    .scl_hist(scl_hist), .sda_hist(sda_hist)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference model: a list of phases per command
  int q_scl[$], q_sda[$], q_len[$], q_smp[$];
  int m_rem, m_kind;
  bit m_busy, m_done, m_open, m_scl, m_sda, m_rx;
  logic [HD-1:0] mh_scl, mh_sda;

  task automatic mpush(input int s, input int d, input int l, input int smp);
    q_scl.push_back(s); q_sda.push_back(d); q_len.push_back(l); q_smp.push_back(smp);
  endtask

  task automatic mbuild(input logic [1:0] op, input bit b);
    int p;
    p = m_sda;
    case (op)
      2'b00: if (m_open) begin
        m_kind = 1;
        mpush(0, p, int'(t_dh) + 1, 0);
        mpush(0, 1, int'(t_lo) + 1, 0);
        mpush(1, 1, int'(t_ri) + int'(t_ss) + 1, 0);
        mpush(1, 0, int'(t_sh) + 1, 0);
        mpush(0, 0, int'(t_fa) + 1, 0);
      end else begin
        m_kind = 0;
        mpush(1, 1, int'(t_ss) + 1, 0);
        mpush(1, 0, int'(t_sh) + 1, 0);
        mpush(0, 0, int'(t_fa) + 1, 0);
      end
      2'b01, 2'b10: begin
        int d;
        d = (op == 2'b10) ? 1 : int'(b);
        m_kind = (op == 2'b10) ? 3 : 2;
        mpush(0, p, int'(t_dh) + 1, 0);
        mpush(0, d, int'(t_lo) + int'(t_ds) + 1, 0);
        mpush(1, d, int'(t_ri) + int'(t_hi) + 1, (op == 2'b10) ? 1 : 0);
        mpush(0, d, int'(t_fa) + 1, 0);
      end
      default: begin
        m_kind = 4;
        mpush(0, p, int'(t_dh) + 1, 0);
        mpush(0, 0, int'(t_lo) + 1, 0);
        mpush(1, 0, int'(t_ri) + int'(t_ps) + 1, 0);
        mpush(1, 1, int'(t_id) + 1, 0);
      end
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_open = 0; m_scl = 1; m_sda = 1; m_rx = 0;
      m_kind = 5; m_rem = 0; mh_scl = '0; mh_sda = '0;
      q_scl.delete(); q_sda.delete(); q_len.delete(); q_smp.delete();
    end else begin
      mh_scl = {mh_scl[HD-2:0], scl_i};
      mh_sda = {mh_sda[HD-2:0], sda_i};
      m_done = 0;
      if (!host_en) begin
        m_busy = 0; m_open = 0; m_scl = 1; m_sda = 1; m_kind = 5;
        q_scl.delete(); q_sda.delete(); q_len.delete(); q_smp.delete();
      end else if (m_busy) begin
        m_rem--;
        if (m_rem == 0) begin
          if (q_smp[0] != 0) m_rx = sda_i;
          void'(q_scl.pop_front()); void'(q_sda.pop_front());
          void'(q_len.pop_front()); void'(q_smp.pop_front());
          if (q_len.size() == 0) begin
            m_busy = 0; m_done = 1;
            if (m_kind == 0 || m_kind == 1) m_open = 1;
            if (m_kind == 4) m_open = 0;
          end else begin
            m_scl = q_scl[0] != 0; m_sda = q_sda[0] != 0; m_rem = q_len[0];
          end
        end
      end else if (cmd_valid) begin
        mbuild(cmd_op, cmd_bit);
        m_busy = 1;
        m_scl = q_scl[0] != 0; m_sda = q_sda[0] != 0; m_rem = q_len[0];
      end
    end
  end

  function automatic string ktag(input int k);
    case (k)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      default: return "R2";
    endcase
  endfunction

  bit p_sda_oe, p_scl_oe, p_ovr, cmp_on;
  initial cmp_on = 0;

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      string lt;
      lt = ovr_en ? "R9" : ktag(m_kind);
      chk(scl_oe == (ovr_en ? !ovr_scl : !m_scl), lt, "scl_oe", scl_oe, ovr_en ? !ovr_scl : !m_scl);
      chk(sda_oe == (ovr_en ? !ovr_sda : !m_sda), lt, "sda_oe", sda_oe, ovr_en ? !ovr_sda : !m_sda);
      chk(busy == m_busy, "R8", "busy", busy, m_busy);
      chk(done == m_done, "R8", "done", done, m_done);
      chk(rx_bit == m_rx, "R6", "rx_bit", rx_bit, m_rx);
      chk(scl_hist == mh_scl, "R10", "scl_hist", scl_hist, mh_scl);
      chk(sda_hist == mh_sda, "R10", "sda_hist", sda_hist, mh_sda);
      if (m_busy && (m_kind == 2 || m_kind == 3) && !ovr_en && !p_ovr && sda_oe != p_sda_oe)
        chk(scl_oe && p_scl_oe, "R5", "scl low at sda change", {p_scl_oe, scl_oe}, 2'b11);
      p_sda_oe = sda_oe; p_scl_oe = scl_oe; p_ovr = ovr_en;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL R8 watchdog actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic send(input logic [1:0] op, input bit b);
    wait_idle();
    cmd_valid = 1; cmd_op = op; cmd_bit = b;
    @(negedge clk);
    cmd_valid = 0;
    chk(busy == 1'b1, "R8", "busy after accept", busy, 1);
  endtask

  task automatic set_tim(input int base);
    t_hi = TW'(base + 3); t_lo = TW'(base + 4); t_ri = TW'(base + 1); t_fa = TW'(base + 1);
    t_ss = TW'(base + 2); t_sh = TW'(base + 2); t_ds = TW'(base + 1); t_dh = TW'(base + 1);
    t_ps = TW'(base + 2); t_id = TW'(base + 5);
  endtask

  task automatic set_zero();
    t_hi = '0; t_lo = '0; t_ri = '0; t_fa = '0; t_ss = '0;
    t_sh = '0; t_ds = '0; t_dh = '0; t_ps = '0; t_id = '0;
  endtask

  initial begin
    rst_n = 0; host_en = 0; ovr_en = 0; ovr_scl = 1; ovr_sda = 1;
    cmd_valid = 0; cmd_op = 2'b00; cmd_bit = 0; tgt_sda = 1;
    set_tim(0);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(scl_oe == 0 && sda_oe == 0, "R1", "oe in reset", {scl_oe, sda_oe}, 0);
    chk(busy == 0 && done == 0, "R1", "busy/done in reset", {busy, done}, 0);
    chk(scl_hist == 0 && sda_hist == 0, "R1", "history in reset", {scl_hist, sda_hist}, 0);
    rst_n = 1;
    cmp_on = 1;

    // R2: commands ignored while disabled
    cmd_valid = 1; cmd_op = 2'b00;
    repeat (4) begin
      @(negedge clk);
      chk(busy == 0 && scl_oe == 0 && sda_oe == 0, "R2", "disabled idle", {busy, scl_oe, sda_oe}, 0);
    end
    cmd_valid = 0;
    host_en = 1;

    // Main sequence, back to back: next command taken in the done cycle
    send(2'b00, 0);
    send(2'b01, 1);
    send(2'b01, 0);
    send(2'b01, 1);
    tgt_sda = 0; send(2'b10, 0); wait_idle();
    chk(rx_bit == 0, "R6", "received bit 0", rx_bit, 0);
    tgt_sda = 1; send(2'b10, 0); wait_idle();
    chk(rx_bit == 1, "R6", "received bit 1", rx_bit, 1);
    send(2'b00, 0);
    send(2'b01, 0);
    send(2'b11, 0);
    send(2'b00, 0);
    send(2'b11, 0);

    // R9: override in the middle of a transmit
    send(2'b00, 0);
    send(2'b01, 1);
    repeat (2) @(negedge clk);
    ovr_en = 1; ovr_scl = 0; ovr_sda = 1;
    repeat (3) @(negedge clk);
    ovr_scl = 1; ovr_sda = 0;
    @(negedge clk);
    chk(scl_oe == 0 && sda_oe == 1, "R9", "override levels", {scl_oe, sda_oe}, 2'b01);
    repeat (2) @(negedge clk);
    ovr_en = 0;
    send(2'b11, 0);

    // R2: clearing enable mid-primitive
    send(2'b00, 0);
    repeat (2) @(negedge clk);
    host_en = 0;
    @(negedge clk);
    chk(busy == 0 && scl_oe == 0 && sda_oe == 0, "R2", "abort releases", {busy, scl_oe, sda_oe}, 0);
    host_en = 1;
    send(2'b00, 0); // fresh START, not repeated
    send(2'b11, 0);

    // All-zero counts: one cycle per phase
    wait_idle();
    set_zero();
    send(2'b00, 0);
    send(2'b01, 0);
    tgt_sda = 0; send(2'b10, 0); wait_idle();
    chk(rx_bit == 0, "R6", "received bit, zero counts", rx_bit, 0);
    tgt_sda = 1;
    send(2'b00, 0);
    send(2'b11, 0);
    wait_idle();
    repeat (20) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule